// File: doc/BRIEF.md
# Shared-Counter Multi-Channel PWM Timer

This block is a small timer with a register port. One prescaled up-counter is shared by a parameterised number of channels. Each channel compares the shared count against its own duty value and drives an edge-aligned PWM output. The output polarity is selectable per channel, and the output can also be forced low. Software programs the period and the duty values through a single-cycle read/write port. Read data is combinational from the address.

The period (modulo) register and every channel duty register are double-buffered. While the counter is stopped, a write reaches the active register at once. While the counter runs, a write waits in a pending register. The active register takes it at the next wrap, so a period never mixes old and new settings. Reads of these registers return the active value, so software can poll until an update has landed. A per-channel match flag records that the count reached the channel's duty value. Software clears the flag by writing a one to it.

Top module: `pwm_shared_timer`

## Requirements
- R1: After reset, every register reads 0 except the channel-count field, the counter is stopped and every PWM output is low.
- R2: Offset 0x04 bits [7:0] read the number of channels and ignore writes. Offset 0x08 is a 32-bit general read/write register.
- R3: In the control register at 0x10, bits [2:0] select a divider of 2^n and bits [4:3] select the run mode. In run mode 1 the counter advances once every 2^n clocks. In any other run mode the counter holds its value.
- R4: Control bit 5 (center-aligned select) always reads 0, and writing it has no effect.
- R5: The counter at 0x14 counts from 0 up to the 16-bit modulo value at 0x18 and then returns to 0, giving a period of modulo+1 ticks.
- R6: With run mode 0, a write to the modulo register or to a channel duty register at 0x24+8n reads back at once. A modulo write leaves the counter value unchanged.
- R7: While the counter runs, those writes are held pending. Reads keep returning the old active value until the counter wraps, and the new value is in force from the next period.
- R8: Any write to the counter offset clears the counter to 0, whatever the written data.
- R9: The channel control register at 0x20+8n has mode bit B at bit 5, mode bit A at bit 4 and a level field at bits [3:2]. With B=1 and level 2'b10, the output is high while count < duty. With level 2'b01 the output is the complement. A duty of 0 gives 0% and a duty above modulo gives 100%.
- R10: Level 2'b00 or 2'b11, or mode bit B = 0, forces the output low. A channel control write changes the output in the very next cycle, without waiting for a wrap.
- R11: Channel control bit 7 is a flag. It is set on a counter tick at which the count equals the channel's active duty value. Writing 1 to it clears it, and writing 0 leaves it unchanged.
- R12: Unmapped, misaligned and unimplemented-channel offsets read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Byte offset of the register access |
| regWrEn | input | 1 | Write strobe for the current cycle |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| pwmOut | output | NUM_CH | Per-channel PWM outputs |
| chFlag | output | NUM_CH | Per-channel match flags |

## Verification
The hardest case to reach is the buffered update. A value must be written while the counter runs but well away from a wrap, then read back as old before the wrap and as new after it. The bench first writes the counter offset, which puts the count at a known phase. It then writes the new duty and modulo within the next two ticks and reads them back immediately. Only after waiting past the wrap does it expect the new values and the new duty ratio.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  localparam int DATA_W = 32;
  localparam int IDX_W  = 8;

  // register byte offsets
  localparam logic [7:0] OFF_PARAM   = 8'h04;
  localparam logic [7:0] OFF_GENERAL = 8'h08;
  localparam logic [7:0] OFF_CTRL    = 8'h10;
  localparam logic [7:0] OFF_COUNT   = 8'h14;
  localparam logic [7:0] OFF_MODULO  = 8'h18;
  localparam logic [7:0] OFF_CH_BASE = 8'h20;

  // channel control field positions
  localparam int FLAG_BIT  = 7;
  localparam int MODEB_BIT = 5;
  localparam int MODEA_BIT = 4;
  localparam int LVL_LSB   = 2;

  localparam logic [1:0] LVL_NORMAL = 2'b10;
  localparam logic [1:0] LVL_INVERT = 2'b01;
  localparam logic [1:0] RUN_TICK   = 2'd1;

  typedef struct packed {
    logic              wrCount;
    logic              wrModulo;
    logic              wrValue;
    logic              clrFlag;
    logic [IDX_W-1:0]  chIdx;
    logic [DATA_W-1:0] wrData;
  } tmr_strobe_t;

endpackage

// File: rtl/pwm_timer_ctrl.sv
module pwm_timer_ctrl
  import pwm_timer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3,
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic                    regWrEn,
  input  logic [DATA_W-1:0]       regWrData,
  output logic [DATA_W-1:0]       regRdData,
  input  logic [CNT_W-1:0]        cntVal,
  input  logic [CNT_W-1:0]        modActive,
  input  logic [NUM_CH*CNT_W-1:0] valActive,
  input  logic [NUM_CH-1:0]       flags,
  output tmr_strobe_t             strobe,
  output logic [PS_W-1:0]         divSel,
  output logic [1:0]              runMode,
  output logic [NUM_CH*2-1:0]     levelSel,
  output logic [NUM_CH-1:0]       modeB
);

  localparam int CH_SPAN = NUM_CH * 8;

  logic [ADDR_W-1:0] chOff;
  logic [IDX_W-1:0]  chIdxW;
  logic              inChRange;
  logic              isChCtrl;
  logic              isChVal;
  logic              hitParam, hitGeneral, hitCtrl, hitCount, hitModulo;

  logic [PS_W-1:0]   divSelQ;
  logic [1:0]        runModeQ;
  logic [DATA_W-1:0] generalQ;
  logic [1:0]        lvlQ   [NUM_CH];
  logic              modeAQ [NUM_CH];
  logic              modeBQ [NUM_CH];

  assign chOff     = regAddr - ADDR_W'(OFF_CH_BASE);
  assign chIdxW    = IDX_W'(chOff >> 3);
  assign inChRange = (regAddr >= ADDR_W'(OFF_CH_BASE)) &&
                     (chOff < ADDR_W'(CH_SPAN)) && (regAddr[1:0] == 2'b00);
  assign isChCtrl  = inChRange && !regAddr[2];
  assign isChVal   = inChRange &&  regAddr[2];

  assign hitParam   = (regAddr == ADDR_W'(OFF_PARAM));
  assign hitGeneral = (regAddr == ADDR_W'(OFF_GENERAL));
  assign hitCtrl    = (regAddr == ADDR_W'(OFF_CTRL));
  assign hitCount   = (regAddr == ADDR_W'(OFF_COUNT));
  assign hitModulo  = (regAddr == ADDR_W'(OFF_MODULO));

  // strobes toward the datapath
  always_comb begin
    strobe          = '0;
    strobe.wrCount  = regWrEn && hitCount;
    strobe.wrModulo = regWrEn && hitModulo;
    strobe.wrValue  = regWrEn && isChVal;
    strobe.clrFlag  = regWrEn && isChCtrl && regWrData[FLAG_BIT];
    strobe.chIdx    = chIdxW;
    strobe.wrData   = regWrData;
  end

  // shared control and general register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divSelQ  <= '0;
      runModeQ <= '0;
      generalQ <= '0;
    end else if (regWrEn) begin
      if (hitCtrl) begin
        divSelQ  <= regWrData[PS_W-1:0];
        runModeQ <= regWrData[PS_W+1:PS_W];
      end
      if (hitGeneral) generalQ <= regWrData;
    end
  end

  // per-channel configuration
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chCfg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lvlQ[g]   <= '0;
        modeAQ[g] <= 1'b0;
        modeBQ[g] <= 1'b0;
      end else if (regWrEn && isChCtrl && chIdxW == IDX_W'(g)) begin
        lvlQ[g]   <= regWrData[LVL_LSB+1:LVL_LSB];
        modeAQ[g] <= regWrData[MODEA_BIT];
        modeBQ[g] <= regWrData[MODEB_BIT];
      end
    end
    assign levelSel[2*g +: 2] = lvlQ[g];
    assign modeB[g]           = modeBQ[g];
  end

  assign divSel  = divSelQ;
  assign runMode = runModeQ;

  // read multiplexer
  always_comb begin
    regRdData = '0;
    if (hitParam)   regRdData = DATA_W'(8'(NUM_CH));
    if (hitGeneral) regRdData = generalQ;
    if (hitCtrl)    regRdData = DATA_W'({runModeQ, divSelQ});
    if (hitCount)   regRdData = DATA_W'(cntVal);
    if (hitModulo)  regRdData = DATA_W'(modActive);
    for (int i = 0; i < NUM_CH; i++) begin
      if (isChCtrl && chIdxW == IDX_W'(i))
        regRdData = DATA_W'({flags[i], 1'b0, modeBQ[i], modeAQ[i], lvlQ[i], 2'b00});
      if (isChVal && chIdxW == IDX_W'(i))
        regRdData = DATA_W'(valActive[i*CNT_W +: CNT_W]);
    end
  end

endmodule

// File: rtl/pwm_timer_datapath.sv
module pwm_timer_datapath
  import pwm_timer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  tmr_strobe_t             strobe,
  input  logic [PS_W-1:0]         divSel,
  input  logic [1:0]              runMode,
  input  logic [NUM_CH*2-1:0]     levelSel,
  input  logic [NUM_CH-1:0]       modeB,
  output logic [CNT_W-1:0]        cntVal,
  output logic [CNT_W-1:0]        modActive,
  output logic [NUM_CH*CNT_W-1:0] valActive,
  output logic [NUM_CH-1:0]       flags,
  output logic [NUM_CH-1:0]       pwmOut
);

  localparam int PRE_W = (1 << PS_W) - 1;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLimit;
  logic             running;
  logic             bufHold;
  logic             tick;
  logic             wrap;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] modPend;
  logic [CNT_W-1:0] modAct;
  logic [CNT_W-1:0] wrVal;

  assign running  = (runMode == RUN_TICK);
  assign bufHold  = (runMode != 2'd0);
  assign preLimit = ~({PRE_W{1'b1}} << divSel);
  assign tick     = running && (preCnt == preLimit);
  assign wrap     = tick && (cntQ == modAct);
  assign wrVal    = strobe.wrData[CNT_W-1:0];

  // prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            preCnt <= '0;
    else if (!running || strobe.wrCount)  preCnt <= '0;
    else if (tick)                        preCnt <= '0;
    else                                  preCnt <= preCnt + PRE_W'(1);
  end

  // shared counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cntQ <= '0;
    else if (strobe.wrCount) cntQ <= '0;
    else if (tick)           cntQ <= wrap ? '0 : cntQ + CNT_W'(1);
  end

  // period register pair
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modPend <= '0;
      modAct  <= '0;
    end else begin
      if (strobe.wrModulo) modPend <= wrVal;
      if (strobe.wrModulo && !bufHold) modAct <= wrVal;
      else if (wrap)                   modAct <= modPend;
    end
  end

  // channels
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [CNT_W-1:0] valPend;
    logic [CNT_W-1:0] valAct;
    logic             flagQ;
    logic             hitMe;
    logic             below;
    logic [1:0]       lvl;

    assign hitMe = (strobe.chIdx == IDX_W'(g));
    assign below = (cntQ < valAct);
    assign lvl   = levelSel[2*g +: 2];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        valPend <= '0;
        valAct  <= '0;
      end else begin
        if (strobe.wrValue && hitMe) valPend <= wrVal;
        if (strobe.wrValue && hitMe && !bufHold) valAct <= wrVal;
        else if (wrap)                           valAct <= valPend;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                           flagQ <= 1'b0;
      else if (tick && cntQ == valAct)     flagQ <= 1'b1;
      else if (strobe.clrFlag && hitMe)    flagQ <= 1'b0;
    end

    always_comb begin
      pwmOut[g] = 1'b0;
      if (modeB[g]) begin
        if (lvl == LVL_NORMAL)      pwmOut[g] = below;
        else if (lvl == LVL_INVERT) pwmOut[g] = ~below;
      end
    end

    assign valActive[g*CNT_W +: CNT_W] = valAct;
    assign flags[g] = flagQ;
  end

  assign cntVal    = cntQ;
  assign modActive = modAct;

endmodule

// File: rtl/pwm_shared_timer.sv
module pwm_shared_timer
  import pwm_timer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic [NUM_CH-1:0] pwmOut,
  output logic [NUM_CH-1:0] chFlag
);

  tmr_strobe_t             strobe;
  logic [PS_W-1:0]         divSel;
  logic [1:0]              runMode;
  logic [NUM_CH*2-1:0]     levelSel;
  logic [NUM_CH-1:0]       modeB;
  logic [CNT_W-1:0]        cntVal;
  logic [CNT_W-1:0]        modActive;
  logic [NUM_CH*CNT_W-1:0] valActive;

  pwm_timer_ctrl #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .PS_W(PS_W), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData),
    .cntVal(cntVal), .modActive(modActive), .valActive(valActive),
    .flags(chFlag),
    .strobe(strobe), .divSel(divSel), .runMode(runMode),
    .levelSel(levelSel), .modeB(modeB)
  );

  pwm_timer_datapath #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .PS_W(PS_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .divSel(divSel), .runMode(runMode),
    .levelSel(levelSel), .modeB(modeB),
    .cntVal(cntVal), .modActive(modActive), .valActive(valActive),
    .flags(chFlag), .pwmOut(pwmOut)
  );

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk
  import pwm_timer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   regAddr,
  input logic                regWrEn,
  input logic [31:0]         regWrData,
  input logic [1:0]          runMode,
  input logic [CNT_W-1:0]    cntVal,
  input logic [CNT_W-1:0]    modActive,
  input logic [NUM_CH*2-1:0] levelSel,
  input logic [NUM_CH-1:0]   pwmOut
);

  logic cntWrite;
  assign cntWrite = regWrEn && (regAddr == ADDR_W'(OFF_COUNT));

  // R8
  count_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntWrite |=> (cntVal == '0));

  // R3
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runMode != RUN_TICK && !cntWrite) |=> $stable(cntVal));

  // R5
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runMode == RUN_TICK && cntVal == modActive && !cntWrite)
      |=> (cntVal == '0 || $stable(cntVal)));

  // R6
  mod_direct_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(OFF_MODULO) && runMode == 2'd0)
      |=> (modActive == $past(regWrData[CNT_W-1:0])));

  // R7
  mod_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runMode == RUN_TICK && cntVal != modActive) |=> $stable(modActive));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lvl
    // R10
    level_off_chk: assert property (@(posedge clk) disable iff (!rstN)
      (levelSel[2*g +: 2] == 2'b00 || levelSel[2*g +: 2] == 2'b11) |-> !pwmOut[g]);
  end

endmodule

bind pwm_shared_timer pwm_timer_chk #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN),
  .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
  .runMode(runMode), .cntVal(cntVal), .modActive(modActive),
  .levelSel(levelSel), .pwmOut(pwmOut)
);

// File: tb/sim_pwm_shared_timer.sv
module sim_pwm_shared_timer;

  localparam int NUM_CH = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [7:0]        regAddr = '0;
  logic              regWrEn = 1'b0;
  logic [31:0]       regWrData = '0;
  logic [31:0]       regRdData;
  logic [NUM_CH-1:0] pwmOut;
  logic [NUM_CH-1:0] chFlag;

  int  total = 0;
  int  bad = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  pwm_shared_timer #(.NUM_CH(NUM_CH)) u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .pwmOut(pwmOut), .chFlag(chFlag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk);
    #1 regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic measureHigh(input int ch, input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1 if (pwmOut[ch]) hi++;
    end
  endtask

  task automatic outNow(input int ch, input logic exp, input string req);
    @(negedge clk);
    #1 check(req, 32'(pwmOut[ch]), 32'(exp));
  endtask

  task automatic testReset();
    logic [31:0] d;
    regRead(8'h10, d); check("R1 control", d, 0);
    regRead(8'h18, d); check("R1 modulo", d, 0);
    regRead(8'h20, d); check("R1 ch0 control", d, 0);
    regRead(8'h24, d); check("R1 ch0 duty", d, 0);
    regRead(8'h08, d); check("R1 general", d, 0);
    check("R1 outputs", 32'(pwmOut), 0);
    repeat (5) @(posedge clk);
    regRead(8'h14, d); check("R1 counter stopped", d, 0);
    regRead(8'h04, d); check("R2 channel count", d, NUM_CH);
  endtask

  task automatic testCountAndPrescale();
    logic [31:0] d;
    regWrite(8'h18, 32'hFF);
    regRead(8'h18, d); check("R6 modulo direct", d, 32'hFF);
    regWrite(8'h10, 32'h08);
    repeat (5) @(posedge clk);
    regWrite(8'h10, 32'h00);
    regRead(8'h14, d); check("R3 divide-by-1 count", d, 6);
    repeat (3) @(posedge clk);
    regRead(8'h14, d); check("R3 stopped hold", d, 6);
    regWrite(8'h18, 32'h3);
    regRead(8'h14, d); check("R6 counter kept on modulo write", d, 6);
    regRead(8'h18, d); check("R6 modulo direct 2", d, 3);
    regWrite(8'h14, 32'h1234);
    regRead(8'h14, d); check("R8 counter clear", d, 0);
    regWrite(8'h18, 32'hFF);
    regWrite(8'h10, 32'h0A);
    repeat (8) @(posedge clk);
    regWrite(8'h10, 32'h02);
    regRead(8'h14, d); check("R3 divide-by-4 count", d, 2);
    regWrite(8'h10, 32'h3F);
    regRead(8'h10, d); check("R4 center bit dropped", d, 32'h1F);
    regWrite(8'h10, 32'h00);
  endtask

  task automatic testWrap();
    logic [31:0] d;
    regWrite(8'h14, 0);
    regWrite(8'h18, 4);
    regWrite(8'h10, 32'h08);
    repeat (6) @(posedge clk);
    regWrite(8'h10, 32'h00);
    regRead(8'h14, d); check("R5 wrap at modulo", d, 2);
  endtask

  task automatic testPwm();
    int hi;
    regWrite(8'h18, 9);
    regWrite(8'h24, 3);
    regWrite(8'h2C, 6);
    regWrite(8'h20, 32'h28);
    regWrite(8'h28, 32'h24);
    regWrite(8'h14, 0);
    regWrite(8'h10, 32'h08);
    repeat (2) @(posedge clk);
    measureHigh(0, 10, hi); check("R9 normal duty 3/10", hi, 3);
    measureHigh(1, 10, hi); check("R9 inverted duty 4/10", hi, 4);
    regWrite(8'h10, 0);
    regWrite(8'h24, 0);
    regWrite(8'h2C, 12);
    regWrite(8'h28, 32'h28);
    regWrite(8'h10, 32'h08);
    measureHigh(0, 10, hi); check("R9 zero duty", hi, 0);
    measureHigh(1, 10, hi); check("R9 full duty", hi, 10);
  endtask

  task automatic testLevel();
    regWrite(8'h28, 32'h20); outNow(1, 1'b0, "R10 level 00 off");
    regWrite(8'h28, 32'h2C); outNow(1, 1'b0, "R10 level 11 off");
    regWrite(8'h28, 32'h08); outNow(1, 1'b0, "R10 mode B clear off");
    regWrite(8'h28, 32'h28); outNow(1, 1'b1, "R10 normal on at once");
    regWrite(8'h28, 32'h24); outNow(1, 1'b0, "R10 inverted at once");
  endtask

  task automatic testBuffer();
    logic [31:0] d;
    int hi;
    regWrite(8'h14, 0);
    regWrite(8'h24, 5);
    regRead(8'h24, d); check("R7 duty held pending", d, 0);
    regWrite(8'h18, 14);
    regRead(8'h18, d); check("R7 modulo held pending", d, 9);
    repeat (12) @(posedge clk);
    regRead(8'h24, d); check("R7 duty loaded at wrap", d, 5);
    regRead(8'h18, d); check("R7 modulo loaded at wrap", d, 14);
    repeat (16) @(posedge clk);
    measureHigh(0, 15, hi); check("R7 new duty 5/15", hi, 5);
  endtask

  task automatic testFlag();
    logic [31:0] d;
    regWrite(8'h10, 0);
    regWrite(8'h3C, 20);
    regWrite(8'h38, 32'h80);
    regWrite(8'h20, 32'hA8);
    regRead(8'h20, d); check("R11 flag cleared", d, 32'h28);
    regWrite(8'h10, 32'h08);
    repeat (20) @(posedge clk);
    regWrite(8'h10, 0);
    regRead(8'h20, d); check("R11 flag set on match", d, 32'hA8);
    regRead(8'h38, d); check("R11 no match no flag", d, 0);
    regWrite(8'h20, 32'h28);
    regRead(8'h20, d); check("R11 write 0 keeps flag", d, 32'hA8);
    regWrite(8'h20, 32'hA8);
    regRead(8'h20, d); check("R11 write 1 clears flag", d, 32'h28);
  endtask

  task automatic testUnmapped();
    logic [31:0] d;
    logic [31:0] cntBefore;
    regRead(8'h14, cntBefore);
    regWrite(8'h40, 32'hFFFF);
    regWrite(8'h44, 32'h7);
    regWrite(8'h1C, 32'h55);
    regWrite(8'h00, 32'h66);
    regWrite(8'h16, 32'h77);
    regWrite(8'h04, 32'h0);
    regRead(8'h40, d); check("R12 channel 4 reads 0", d, 0);
    regRead(8'h1C, d); check("R12 gap reads 0", d, 0);
    regRead(8'h16, d); check("R12 misaligned reads 0", d, 0);
    regRead(8'h18, d); check("R12 modulo untouched", d, 14);
    regRead(8'h24, d); check("R12 ch0 duty untouched", d, 5);
    regRead(8'h14, d); check("R12 counter untouched", d, cntBefore);
    regRead(8'h04, d); check("R2 count read-only", d, NUM_CH);
    regWrite(8'h08, 32'hA5A51234);
    regRead(8'h08, d); check("R2 general read/write", d, 32'hA5A51234);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    testReset();
    testCountAndPrescale();
    testWrap();
    testPwm();
    testLevel();
    testBuffer();
    testFlag();
    testUnmapped();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule